// File: doc/BRIEF.md
# SPI Flash Serial Front End

This block is the serial-side front end of a serial flash device. It watches the chip select, serial clock, serial data in, hold and write-protect pins. It oversamples all of them with the device's system clock. Serial input bits are taken on serial clock rising edges and gathered MSB first into bytes. Each completed byte goes to a command decoder with a one-cycle strobe. Bytes to transmit come from the decoder and are shifted out MSB first, with the output changing only after serial clock falling edges.

The front end ignores the bus after reset until it sees a genuine high-to-low transition of chip select. Raising chip select aborts any partial byte and turns off the output driver. A hold pin pauses a transfer while the device stays selected. During a hold the output driver is off, the serial clock and data are ignored, and the bit position and shift contents survive. The block also owns the three block-protect bits of the status register, and the write-protect pin can lock them. It reports standby when the device is deselected and no internal cycle is running. Both clock-idle polarities (modes 0 and 3) are served by the same edge logic.

Top module: `spi_flash_front`

## Requirements
- R1: Serial input is sampled on each serial clock rising edge while selected and not held, MSB first. After the 8th rising edge of a byte, `rx_valid` is high for exactly one system clock with the full byte on `rx_byte`.
- R2: `miso` changes only after a serial clock falling edge, or at the chip select falling edge that starts a frame, which presents bit 7 of `tx_byte`.
- R3: While `csn` is high, `miso_oe` is low. Raising `csn` discards a partial byte, so the next frame starts again at bit 7.
- R4: After reset, no byte is received and `miso_oe` stays low until `csn` has gone from high to low. A `csn` that is already low at reset release does not count.
- R5: With `holdn` low while selected, `miso_oe` is low, and serial clock and data edges are ignored. The bit position and the partial received byte are kept, so the byte completes correctly after release.
- R6: Hold entry and exit take effect only while `sck` is low. A `holdn` change while `sck` is high waits until `sck` goes low. A hold requested while `csn` is high has no effect.
- R7: Mode 0 (clock idles low) and mode 3 (clock idles high) transfer the same bytes. In mode 3, the falling edge before the first rising edge of a frame does not advance the output.
- R8: A pulse on `bp_wr` copies `bp_wdata` into `bp` only when `wpn` is high. With `wpn` low, `bp` keeps its value.
- R9: `standby` is high exactly when `csn` is high and `busy` is low.
- R10: After each full byte, the first serial clock falling edge loads a new `tx_byte`, whose bit 7 then appears on `miso`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| csn | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| holdn | input | 1 | Hold request, active low |
| wpn | input | 1 | Write protect, active low |
| busy | input | 1 | Internal program/erase/status cycle running |
| tx_byte | input | W | Next byte to transmit |
| bp_wr | input | 1 | Block-protect write strobe from the decoder |
| bp_wdata | input | BPW | Block-protect value to write |
| miso | output | 1 | Serial data out value |
| miso_oe | output | 1 | Serial data out driver enable |
| rx_byte | output | W | Last received byte |
| rx_valid | output | 1 | One-cycle received-byte strobe |
| bp | output | BPW | Block-protect bits |
| standby | output | 1 | Deselected and idle |

## Verification
A wrong bit counter shows up at the next byte boundary, as an early, late or missing `rx_valid` and as a shifted `rx_byte`. It also skews the `miso` stream at the next falling edge. A hold flag that is set wrongly turns `miso_oe` off, or leaves it on, in the very next system cycle. A lost arm flag or a bad edge detector changes `miso_oe` or `miso` within one serial clock. The bench's reference model compares every output on every system clock, so each of these faults is reported within a few cycles.

// File: rtl/spi_flash_front.sv
module spi_flash_front #(
  parameter int W   = 8,
  parameter int BPW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sck,
  input  logic           csn,
  input  logic           mosi,
  input  logic           holdn,
  input  logic           wpn,
  input  logic           busy,
  input  logic [W-1:0]   tx_byte,
  input  logic           bp_wr,
  input  logic [BPW-1:0] bp_wdata,
  output logic           miso,
  output logic           miso_oe,
  output logic [W-1:0]   rx_byte,
  output logic           rx_valid,
  output logic [BPW-1:0] bp,
  output logic           standby
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          sck_q, csn_q, armed, held, first, dout;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rx_sh, tx_sh;

  wire csn_fall = !csn && csn_q;
  wire rise     = sck && !sck_q;
  wire fall     = !sck && sck_q;
  wire sel      = !csn && armed;

  assign miso_oe = sel && !held;
  assign miso    = dout;
  assign standby = csn && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      csn_q    <= 1'b0;
      armed    <= 1'b0;
      held     <= 1'b0;
      first    <= 1'b1;
      dout     <= 1'b0;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      bp       <= '0;
    end else begin
      sck_q    <= sck;
      csn_q    <= csn;
      rx_valid <= 1'b0;
      if (bp_wr && wpn) bp <= bp_wdata;
      if (csn_fall) armed <= 1'b1;
      if (csn) begin
        held  <= 1'b0;
        cnt   <= '0;
        rx_sh <= '0;
        first <= 1'b1;
      end else if (csn_fall) begin
        held  <= 1'b0;
        cnt   <= '0;
        first <= 1'b1;
        dout  <= tx_byte[W-1];
        tx_sh <= {tx_byte[W-2:0], 1'b0};
      end else if (armed) begin
        if (!sck) held <= !holdn;
        if (!held) begin
          if (rise) begin
            rx_sh <= {rx_sh[W-2:0], mosi};
            first <= 1'b0;
            if (cnt == LAST) begin
              cnt      <= '0;
              rx_valid <= 1'b1;
              rx_byte  <= {rx_sh[W-2:0], mosi};
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (fall && !first) begin
            if (cnt == '0) begin
              dout  <= tx_byte[W-1];
              tx_sh <= {tx_byte[W-2:0], 1'b0};
            end else begin
              dout  <= tx_sh[W-1];
              tx_sh <= {tx_sh[W-2:0], 1'b0};
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_flash_front_chk.sv
module spi_flash_front_chk #(
  parameter int BPW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sck,
  input logic           csn,
  input logic           sck_q,
  input logic           csn_q,
  input logic           armed,
  input logic           held,
  input logic           miso,
  input logic           miso_oe,
  input logic           rx_valid,
  input logic           bp_wr,
  input logic           wpn,
  input logic [BPW-1:0] bp
);
  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_miso_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && $past(miso_oe) && !$past(csn_q) && (miso != $past(miso)))
      |-> ($past(sck_q) && !$past(sck)));

  p_desel_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    csn |-> !miso_oe);

  p_unarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !rx_valid);

  p_hold_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> !rx_valid);

  p_hold_sck_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn && $past(!csn) && $changed(held)) |-> !$past(sck));

  p_bp_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_wr && !wpn) |=> $stable(bp));
endmodule

bind spi_flash_front spi_flash_front_chk #(.BPW(BPW)) u_chk (.*);

// File: tb/test_spi_flash_front.sv
`timescale 1ns/1ps
module test_spi_flash_front;
  logic clk = 0, rst_n = 0;
  logic sck = 0, csn = 1, mosi = 0, holdn = 1, wpn = 1, busy = 0, bp_wr = 0;
  logic [7:0] tx_byte = 8'h00;
  logic [2:0] bp_wdata = 3'b000;
  logic miso, miso_oe, rx_valid, standby;
  logic [7:0] rx_byte;
  logic [2:0] bp;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_flash_front i_spi_flash_front (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .mosi(mosi), .holdn(holdn),
    .wpn(wpn), .busy(busy), .tx_byte(tx_byte), .bp_wr(bp_wr), .bp_wdata(bp_wdata),
    .miso(miso), .miso_oe(miso_oe), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .bp(bp), .standby(standby));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_armed, m_held, m_first, m_dout, m_valid, p_sck, p_csn;
  int m_bits, m_acc, m_byte, m_bp;
  bit m_txq[$];

  task automatic m_load();
    m_txq.delete();
    for (int i = 7; i >= 0; i--) m_txq.push_back(tx_byte[i]);
    m_dout = m_txq.pop_front();
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_armed = 0; m_held = 0; m_first = 1; m_dout = 0; m_valid = 0;
      p_sck = 0; p_csn = 0; m_bits = 0; m_acc = 0; m_byte = 0; m_bp = 0;
      m_txq.delete();
    end else begin
      bit r, f, cf, oh;
      r = sck && !p_sck; f = !sck && p_sck; cf = !csn && p_csn;
      m_valid = 0;
      if (bp_wr && wpn) m_bp = bp_wdata;
      if (csn) begin
        m_held = 0; m_bits = 0; m_acc = 0; m_first = 1;
      end else if (cf) begin
        m_held = 0; m_bits = 0; m_first = 1; m_load();
      end else if (m_armed) begin
        oh = m_held;
        if (!sck) m_held = !holdn;
        if (!oh) begin
          if (r) begin
            m_acc = ((m_acc << 1) | mosi) & 255;
            m_bits++; m_first = 0;
            if (m_bits == 8) begin m_valid = 1; m_byte = m_acc; m_bits = 0; end
          end else if (f && !m_first) begin
            if (m_bits == 0) m_load();
            else if (m_txq.size() > 0) m_dout = m_txq.pop_front();
          end
        end
      end
      if (cf) m_armed = 1;
      p_sck = sck; p_csn = csn;
    end
  end

  bit got_q[$];
  int rxq[$];
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit m_oe;
      m_oe = !csn && m_armed && !m_held;
      check(rx_valid == m_valid, "R1 rx_valid", rx_valid, m_valid);
      if (m_valid) check(rx_byte == m_byte[7:0], "R1 rx_byte", rx_byte, m_byte);
      check(miso_oe == m_oe, "R3 miso_oe", miso_oe, m_oe);
      if (m_oe) check(miso == m_dout, "R2 miso", miso, m_dout);
      check(bp == m_bp[2:0], "R8 bp", bp, m_bp);
      check(standby == (csn && !busy), "R9 standby", standby, csn && !busy);
      if (rx_valid) rxq.push_back(rx_byte);
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic bit_clk(input bit b, output bit got);
    sck = 0; mosi = b; step(2);
    got = miso;
    sck = 1; step(2);
  endtask

  task automatic xfer(input [7:0] b, output [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      bit g;
      bit_clk(b[i], g);
      got[i] = g;
    end
  endtask

  task automatic frame_start(input bit idle, input [7:0] first_tx);
    sck = idle; tx_byte = first_tx; step(2);
    csn = 0; step(2);
  endtask

  task automatic frame_end(input bit idle);
    sck = idle; step(2);
    csn = 1; step(2);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] got;
    bit g;
    // R4: csn already low at reset release does not arm
    csn = 0;
    step(3);
    rst_n = 1;
    #1;
    check(!rx_valid && !miso_oe, "R4 reset state", {rx_valid, miso_oe}, 0);
    check(standby == 0, "R9 standby while selected", standby, 0);
    xfer(8'hFF, got);
    step(2);
    check(rxq.size() == 0, "R4 no byte before first csn fall", rxq.size(), 0);
    check(!miso_oe, "R4 output off before arming", miso_oe, 0);
    sck = 0; csn = 1; step(2);
    check(standby == 1, "R9 standby idle", standby, 1);
    busy = 1; step(1);
    check(standby == 0, "R9 standby busy", standby, 0);
    busy = 0;

    // R1 R2 R10 mode 0, two bytes
    frame_start(0, 8'h96);
    check(miso_oe && miso == 1'b1, "R2 first bit at csn fall", miso, 1);
    xfer(8'hA5, got);
    check(got == 8'h96, "R2 tx byte 0", got, 8'h96);
    tx_byte = 8'h5A;
    xfer(8'h3C, got);
    check(got == 8'h5A, "R10 tx byte 1", got, 8'h5A);
    frame_end(0);
    check(rxq.size() == 2 && rxq[0] == 8'hA5 && rxq[1] == 8'h3C, "R1 mode0 bytes",
          (rxq.size() == 2) ? {rxq[0][7:0], rxq[1][7:0]} : 0, 16'hA53C);
    rxq.delete();

    // R7 mode 3
    frame_start(1, 8'hC3);
    xfer(8'h71, got);
    check(got == 8'hC3, "R7 mode3 tx", got, 8'hC3);
    tx_byte = 8'h0F;
    xfer(8'hE8, got);
    check(got == 8'h0F, "R7 mode3 tx byte 1", got, 8'h0F);
    frame_end(1);
    check(rxq.size() == 2 && rxq[0] == 8'h71 && rxq[1] == 8'hE8, "R7 mode3 bytes",
          rxq.size(), 2);
    rxq.delete();

    // R3 partial byte aborted
    frame_start(0, 8'h11);
    for (int i = 0; i < 3; i++) bit_clk(1'b1, g);
    frame_end(0);
    check(!miso_oe, "R3 output off when deselected", miso_oe, 0);
    frame_start(0, 8'h22);
    xfer(8'h4B, got);
    frame_end(0);
    check(rxq.size() == 1 && rxq[0] == 8'h4B, "R3 restart at bit 7",
          (rxq.size() > 0) ? rxq[0] : -1, 8'h4B);
    rxq.delete();

    // R5 R6 hold mid-byte
    frame_start(0, 8'hB4);
    for (int i = 7; i >= 4; i--) bit_clk(8'hD2 >> i, g);
    holdn = 0; step(3);
    check(miso_oe == 1, "R6 no hold entry while sck high", miso_oe, 1);
    sck = 0; step(2);
    check(miso_oe == 0, "R5 output off in hold", miso_oe, 0);
    for (int i = 0; i < 5; i++) begin
      sck = 1; mosi = i[0]; step(2); sck = 0; step(2);
    end
    check(rxq.size() == 0, "R5 clock ignored in hold", rxq.size(), 0);
    sck = 1; step(2);
    holdn = 1; step(3);
    check(miso_oe == 0, "R6 no hold exit while sck high", miso_oe, 1'b0);
    for (int i = 3; i >= 0; i--) bit_clk(8'hD2 >> i, g);
    frame_end(0);
    check(rxq.size() == 1 && rxq[0] == 8'hD2, "R5 byte kept across hold",
          (rxq.size() > 0) ? rxq[0] : -1, 8'hD2);
    rxq.delete();

    // R6 hold while deselected has no effect
    holdn = 0; step(4); holdn = 1; step(1);
    frame_start(0, 8'h00);
    check(miso_oe == 1, "R6 hold while deselected ignored", miso_oe, 1);
    frame_end(0);

    // R8 write protect
    bp_wdata = 3'b101; bp_wr = 1; step(1); bp_wr = 0; step(1);
    check(bp == 3'b101, "R8 bp written", bp, 3'b101);
    wpn = 0; bp_wdata = 3'b010; bp_wr = 1; step(1); bp_wr = 0; step(1);
    check(bp == 3'b101, "R8 bp locked", bp, 3'b101);
    wpn = 1; bp_wr = 1; step(1); bp_wr = 0; step(1);
    check(bp == 3'b010, "R8 bp unlocked", bp, 3'b010);

    step(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule